// File: doc/BRIEF.md
# Deep Sleep Entry and Wake Controller

This block is the always-on power-state controller of a small microcontroller. Software arms deep sleep through a guarded write sequence on a small register port, then issues the sleep instruction. Depending on a software retention request and a static retention configuration input, the controller enters either plain deep sleep, where core power is cut, or retention deep sleep, where core power is cut but a retention regulator keeps data RAM alive. A sleep instruction that arrives without a valid arm puts the core into ordinary sleep.

While in a deep state the controller watches five wake events, which arrive as one-cycle pulses from the always-on monitors. It records every event present in the waking cycle in a wake-status field. On a plain exit it requests a power-on reset, forces the default oscillator and sets a sticky exit flag. On a retention exit it resumes execution on the previous clock source with no reset. Four context registers, the control bits and the status field live in the always-on domain and survive a plain exit. The normal-mode watchdog can end ordinary sleep but never a deep state.

Top module: `dsleep_ctrl`

## Requirements
- R1: After `rst`, `core_pwr_en`=1, `ret_reg_en`=0, `lite_sleep`=0, `por_req`=0, `resume`=0, `clk_default`=0, and reads of addresses 0 to 5 return 0.
- R2: Arming needs two consecutive writes to address 0 with bit 0 set. A `sleep_instr` after only one such write enters ordinary sleep (`lite_sleep`=1, `core_pwr_en` stays 1). Reading address 0 returns the armed state in bit 0 and the retention request in bit 1.
- R3: The sleep instruction must directly follow the arm. An `instr_step` pulse, a write to any address other than 0, or a write to address 0 with bit 0 clear drops the arm count to zero.
- R4: A deep entry goes to retention (`core_pwr_en`=0, `ret_reg_en`=1) only if address 0 bit 1 was already 1 before the first arming write and `ret_cfg`=1. Otherwise it goes to plain deep sleep (`core_pwr_en`=0, `ret_reg_en`=0).
- R5: Deep entry clears the wake-status field (address 1 bits 4:0). A wake sets the bits of all events present: bit 0 reset pin, bit 1 power-on reset, bit 2 RTC alarm, bit 3 INT0, bit 4 deep-sleep watchdog.
- R6: One cycle after a wake event in plain deep sleep, `core_pwr_en`=1, `por_req` and `clk_default` pulse high for exactly one cycle, and the exit flag (address 1 bit 7) is set. The flag holds until a write to address 1 with bit 7 set.
- R7: One cycle after a wake event in retention deep sleep, `core_pwr_en`=1, `ret_reg_en`=0, `resume` pulses for one cycle, and `por_req`, `clk_default` and the exit flag stay unchanged at their prior levels (pulses 0).
- R8: Context registers (addresses 2 to 5) and the retention request bit keep their values across a plain deep-sleep exit.
- R9: `norm_wdt` has no effect on either deep state, but it ends ordinary sleep, as does any wake event.
- R10: Every sleep entry clears the arm count, so a following entry needs a fresh double write.
- R11: With no wake event, a deep state holds its power outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset of the always-on domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| instr_step | input | 1 | Pulse for each retired instruction other than sleep and writes to this block |
| sleep_instr | input | 1 | Sleep instruction strobe |
| ret_cfg | input | 1 | Static retention configuration enable |
| wake_evt | input | 5 | Deep-sleep wake event pulses (layout in R5) |
| norm_wdt | input | 1 | Normal-mode watchdog event |
| core_pwr_en | output | 1 | Core power enable |
| ret_reg_en | output | 1 | Retention regulator enable |
| lite_sleep | output | 1 | Ordinary sleep indication |
| por_req | output | 1 | Power-on reset request pulse |
| resume | output | 1 | Resume-execution pulse after retention wake |
| clk_default | output | 1 | Pulse selecting the default configured oscillator |

## Verification
The bench targets the arm window. It covers a single write, a write followed by an unrelated instruction, a write to another register, and a clearing write. A design that counts loosely would drop into deep sleep where ordinary sleep is due. It checks that the retention request only counts when set before the first arming write; a design sampling it at the sleep strobe would pick retention wrongly. It also drives simultaneous wake events and checks that every bit latches. It sends the normal watchdog into a deep state, where a confused design would wake. Finally, it checks that context and the exit flag survive a plain exit while the reset and clock pulses last exactly one cycle.

// File: rtl/dsleep_pkg.sv
package dsleep_pkg;

    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int WAKE_N   = 5;
    localparam int CTX_N    = 4;

    localparam logic [ADDR_W-1:0] A_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT     = 3'd1;
    localparam int                CTX_BASE   = 2;

    localparam int B_ARM      = 0;
    localparam int B_KEEP     = 1;
    localparam int B_FLAG     = DATA_W - 1;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_LITE = 2'd1,
        PS_DEEP = 2'd2,
        PS_DRET = 2'd3
    } pstate_e;

    typedef struct packed {
        logic enter_deep;
        logic exit_plain;
        logic exit_ret;
    } fsm_evt_t;

    function automatic logic is_ctx(input logic [ADDR_W-1:0] a);
        return (int'(a) >= CTX_BASE) && (int'(a) < CTX_BASE + CTX_N);
    endfunction

endpackage

// File: rtl/dsleep_arm.sv
module dsleep_arm
    import dsleep_pkg::*;
#(
    parameter int ARM_WRITES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_run,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_bits,
    input  logic              instr_step,
    input  logic              sleep_instr,
    output logic              armed,
    output logic              keep_ram,
    output logic              ret_pick
);
    localparam int CNT_W = $clog2(ARM_WRITES + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ARM_WRITES);

    logic [CNT_W-1:0] cnt;
    logic             ctrl_wr;

    assign ctrl_wr = in_run && wr_en && (wr_addr == A_CTRL);
    assign armed   = (cnt == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            keep_ram <= 1'b0;
            ret_pick <= 1'b0;
        end else if (in_run) begin
            if (sleep_instr) begin
                cnt <= '0;
            end else if (ctrl_wr) begin
                keep_ram <= wr_bits[B_KEEP];
                if (wr_bits[B_ARM]) begin
                    if (cnt == '0)
                        ret_pick <= keep_ram;
                    if (cnt != CNT_TOP)
                        cnt <= cnt + 1'b1;
                end else begin
                    cnt <= '0;
                end
            end else if (wr_en || instr_step) begin
                cnt <= '0;
            end
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/dsleep_wake.sv
module dsleep_wake
    import dsleep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fsm_evt_t          ev,
    input  logic [WAKE_N-1:0] wake_evt,
    input  logic              flag_clr,
    output logic [WAKE_N-1:0] wake_src,
    output logic              exit_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wake_src  <= '0;
            exit_flag <= 1'b0;
        end else begin
            if (ev.enter_deep)
                wake_src <= '0;
            else if (ev.exit_plain || ev.exit_ret)
                wake_src <= wake_evt;

            if (ev.exit_plain)
                exit_flag <= 1'b1;
            else if (flag_clr)
                exit_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/dsleep_ctx.sv
module dsleep_ctx
    import dsleep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctx [CTX_N]
);
    for (genvar i = 0; i < CTX_N; i++) begin : g_ctx
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTX_BASE + i);
        always_ff @(posedge clk) begin
            if (rst)
                ctx[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                ctx[i] <= wr_data;
        end
    end

endmodule

// File: rtl/dsleep_fsm.sv
module dsleep_fsm
    import dsleep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_instr,
    input  logic              armed,
    input  logic              ret_pick,
    input  logic              ret_cfg,
    input  logic [WAKE_N-1:0] wake_evt,
    input  logic              norm_wdt,
    output pstate_e           st,
    output fsm_evt_t          ev,
    output logic              por_req,
    output logic              resume,
    output logic              clk_default
);
    logic any_wake;
    assign any_wake = |wake_evt;

    always_comb begin
        ev            = '0;
        ev.enter_deep = (st == PS_RUN) && sleep_instr && armed;
        ev.exit_plain = (st == PS_DEEP) && any_wake;
        ev.exit_ret   = (st == PS_DRET) && any_wake;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= PS_RUN;
            por_req     <= 1'b0;
            resume      <= 1'b0;
            clk_default <= 1'b0;
        end else begin
            por_req     <= 1'b0;
            resume      <= 1'b0;
            clk_default <= 1'b0;
            unique case (st)
                PS_RUN: begin
                    if (sleep_instr) begin
                        if (!armed)
                            st <= PS_LITE;
                        else if (ret_pick && ret_cfg)
                            st <= PS_DRET;
                        else
                            st <= PS_DEEP;
                    end
                end
                PS_LITE: begin
                    if (any_wake || norm_wdt)
                        st <= PS_RUN;
                end
                PS_DEEP: begin
                    if (any_wake) begin
                        st          <= PS_RUN;
                        por_req     <= 1'b1;
                        clk_default <= 1'b1;
                    end
                end
                PS_DRET: begin
                    if (any_wake) begin
                        st     <= PS_RUN;
                        resume <= 1'b1;
                    end
                end
                default: st <= PS_RUN;
            endcase
        end
    end

endmodule

// File: rtl/dsleep_ctrl.sv
module dsleep_ctrl
    import dsleep_pkg::*;
#(
    parameter int ARM_WRITES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              instr_step,
    input  logic              sleep_instr,
    input  logic              ret_cfg,
    input  logic [WAKE_N-1:0] wake_evt,
    input  logic              norm_wdt,
    output logic              core_pwr_en,
    output logic              ret_reg_en,
    output logic              lite_sleep,
    output logic              por_req,
    output logic              resume,
    output logic              clk_default
);
    pstate_e           st;
    fsm_evt_t          ev;
    logic              in_run;
    logic              armed;
    logic              keep_ram;
    logic              ret_pick;
    logic [WAKE_N-1:0] wake_src;
    logic              exit_flag;
    logic              flag_clr;
    logic              run_wr;
    logic [DATA_W-1:0] ctx [CTX_N];

    assign in_run   = (st == PS_RUN);
    assign run_wr   = in_run && wr_en;
    assign flag_clr = run_wr && (wr_addr == A_STAT) && wr_data[B_FLAG];

    dsleep_arm #(.ARM_WRITES(ARM_WRITES)) u_arm (
        .clk         (clk),
        .rst         (rst),
        .in_run      (in_run),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_bits     (wr_data[1:0]),
        .instr_step  (instr_step),
        .sleep_instr (sleep_instr),
        .armed       (armed),
        .keep_ram    (keep_ram),
        .ret_pick    (ret_pick)
    );

    dsleep_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sleep_instr (sleep_instr),
        .armed       (armed),
        .ret_pick    (ret_pick),
        .ret_cfg     (ret_cfg),
        .wake_evt    (wake_evt),
        .norm_wdt    (norm_wdt),
        .st          (st),
        .ev          (ev),
        .por_req     (por_req),
        .resume      (resume),
        .clk_default (clk_default)
    );

    dsleep_wake u_wake (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .wake_evt  (wake_evt),
        .flag_clr  (flag_clr),
        .wake_src  (wake_src),
        .exit_flag (exit_flag)
    );

    dsleep_ctx u_ctx (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (run_wr),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctx     (ctx)
    );

    assign core_pwr_en = (st == PS_RUN) || (st == PS_LITE);
    assign ret_reg_en  = (st == PS_DRET);
    assign lite_sleep  = (st == PS_LITE);

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data[B_ARM]  = armed;
            rd_data[B_KEEP] = keep_ram;
        end else if (rd_addr == A_STAT) begin
            rd_data[WAKE_N-1:0] = wake_src;
            rd_data[B_FLAG]     = exit_flag;
        end else if (is_ctx(rd_addr)) begin
            rd_data = ctx[int'(rd_addr) - CTX_BASE];
        end
    end

endmodule

// File: rtl/dsleep_chk.sv
module dsleep_chk
    import dsleep_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WAKE_N-1:0] wake_evt,
    input logic              sleep_instr,
    input logic              armed,
    input logic              core_pwr_en,
    input logic              ret_reg_en,
    input logic              por_req,
    input logic              resume,
    input logic              clk_default
);
    p_reg_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(core_pwr_en && ret_reg_en));

    p_unarmed_stays_on_r2: assert property (@(posedge clk) disable iff (rst)
        (core_pwr_en && !armed && sleep_instr) |=> core_pwr_en);

    p_deep_wakes_r6: assert property (@(posedge clk) disable iff (rst)
        (!core_pwr_en && wake_evt != '0) |=> core_pwr_en);

    p_deep_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (!core_pwr_en && wake_evt == '0) |=> (!core_pwr_en && $stable(ret_reg_en)));

    p_por_from_plain_r6: assert property (@(posedge clk) disable iff (rst)
        por_req |-> $past(!core_pwr_en && !ret_reg_en));

    p_clk_with_por_r6: assert property (@(posedge clk) disable iff (rst)
        clk_default |-> por_req);

    p_resume_from_ret_r7: assert property (@(posedge clk) disable iff (rst)
        resume |-> ($past(ret_reg_en) && !por_req && !clk_default));

endmodule

bind dsleep_ctrl dsleep_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wake_evt    (wake_evt),
    .sleep_instr (sleep_instr),
    .armed       (armed),
    .core_pwr_en (core_pwr_en),
    .ret_reg_en  (ret_reg_en),
    .por_req     (por_req),
    .resume      (resume),
    .clk_default (clk_default)
);

// File: tb/dsleep_ctrl_bench.sv
module dsleep_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic       instr_step, sleep_instr, ret_cfg, norm_wdt;
    logic [4:0] wake_evt;
    logic       core_pwr_en, ret_reg_en, lite_sleep, por_req, resume, clk_default;

    always #5 clk = ~clk;

    dsleep_ctrl u_dsleep_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .instr_step(instr_step),
        .sleep_instr(sleep_instr), .ret_cfg(ret_cfg), .wake_evt(wake_evt),
        .norm_wdt(norm_wdt), .core_pwr_en(core_pwr_en), .ret_reg_en(ret_reg_en),
        .lite_sleep(lite_sleep), .por_req(por_req), .resume(resume),
        .clk_default(clk_default)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model: 0 run, 1 ordinary sleep, 2 plain deep, 3 retention deep
    int         m_state;
    int         m_cnt;
    logic       m_keep, m_retl, m_flag;
    logic [4:0] m_src;
    logic [7:0] m_ctx [4];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int a);
        if (a == 0) return {6'b0, m_keep, m_cnt == 2};
        if (a == 1) return {m_flag, 2'b00, m_src};
        if (a >= 2 && a <= 5) return m_ctx[a-2];
        return 8'h00;
    endfunction

    task automatic read_chk(input string req, input int a);
        rd_addr = 3'(a);
        #1;
        chk(req, rd_data, exp_read(a));
    endtask

    task automatic pwr_chk(input string req);
        chk({req, " core"}, core_pwr_en, (m_state < 2));
        chk({req, " ret"}, ret_reg_en, (m_state == 3));
        chk({req, " lite"}, lite_sleep, (m_state == 1));
    endtask

    task automatic quiet;
        wr_en = 0; instr_step = 0; sleep_instr = 0; wake_evt = '0; norm_wdt = 0;
    endtask

    task automatic op_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        quiet();
        if (a == 0) begin
            if (d[0]) begin
                if (m_cnt == 0) m_retl = m_keep;
                if (m_cnt < 2) m_cnt++;
            end else m_cnt = 0;
            m_keep = d[1];
        end else begin
            m_cnt = 0;
            if (a == 1 && d[7]) m_flag = 0;
            if (a >= 2 && a <= 5) m_ctx[a-2] = d;
        end
    endtask

    task automatic op_step;
        @(negedge clk); instr_step = 1;
        @(negedge clk); quiet();
        m_cnt = 0;
    endtask

    task automatic op_sleep(input string req);
        @(negedge clk); sleep_instr = 1;
        @(negedge clk); quiet();
        if (m_cnt == 2) begin
            m_state = (m_retl && ret_cfg) ? 3 : 2;
            m_src = '0;
        end else m_state = 1;
        m_cnt = 0;
        pwr_chk(req);
    endtask

    task automatic op_wake(input string req, input logic [4:0] ev, input logic nw);
        logic ep, er;
        ep = 0; er = 0;
        @(negedge clk); wake_evt = ev; norm_wdt = nw;
        @(negedge clk); quiet();
        if (m_state == 2 && ev != 0) begin
            m_state = 0; m_src = ev; m_flag = 1; ep = 1;
        end else if (m_state == 3 && ev != 0) begin
            m_state = 0; m_src = ev; er = 1;
        end else if (m_state == 1 && (ev != 0 || nw)) m_state = 0;
        chk({req, " por_req"}, por_req, ep);
        chk({req, " clk_default"}, clk_default, ep);
        chk({req, " resume"}, resume, er);
        pwr_chk(req);
        @(negedge clk);
        chk({req, " pulse width"}, {por_req, clk_default, resume}, 3'b000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; quiet(); wr_addr = 0; wr_data = 0; rd_addr = 0; ret_cfg = 0;
        m_state = 0; m_cnt = 0; m_keep = 0; m_retl = 0; m_flag = 0; m_src = 0;
        for (int i = 0; i < 4; i++) m_ctx[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        pwr_chk("R1");
        chk("R1 pulses", {por_req, resume, clk_default}, 3'b000);
        for (int a = 0; a < 6; a++) read_chk("R1 read", a);

        for (int i = 0; i < 4; i++) op_write(3'(2 + i), 8'(8'h5A + i * 17));
        // R2 single write then sleep -> ordinary sleep
        op_write(0, 8'h01);
        read_chk("R2 half arm", 0);
        op_sleep("R2 single write");
        op_wake("R9 norm_wdt ends ordinary sleep", 5'b0, 1'b1);
        // R3 arm then unrelated instruction
        op_write(0, 8'h01); op_write(0, 8'h01);
        read_chk("R2 armed readback", 0);
        op_step();
        op_sleep("R3 step breaks arm");
        op_wake("R9 event ends ordinary sleep", 5'b00100, 1'b0);
        // R3 arm then write elsewhere
        op_write(0, 8'h01); op_write(0, 8'h01); op_write(3, 8'hC3);
        op_sleep("R3 other write breaks arm");
        op_wake("R9 wake", 5'b00001, 1'b0);
        // R3 clearing write
        op_write(0, 8'h01); op_write(0, 8'h00); op_write(0, 8'h01);
        op_sleep("R3 clearing write");
        op_wake("R9 wake", 5'b00010, 1'b0);
        // R4 plain deep
        op_write(0, 8'h01); op_write(0, 8'h01);
        op_sleep("R4 plain deep");
        read_chk("R5 status cleared", 1);
        op_wake("R9 norm_wdt ignored in deep", 5'b0, 1'b1);
        repeat (5) op_wake("R11 hold in deep", 5'b0, 1'b0);
        op_wake("R6 plain exit", 5'b00101, 1'b0);
        read_chk("R5 R6 status and flag", 1);
        for (int a = 2; a < 6; a++) read_chk("R8 context kept", a);
        op_write(2, 8'h11);
        read_chk("R6 flag sticky", 1);
        op_write(1, 8'h80);
        read_chk("R6 flag cleared", 1);
        // R10 fresh double write needed
        op_write(0, 8'h01);
        op_sleep("R10 single after wake");
        op_wake("R9 wake", 5'b01000, 1'b0);
        // R4 retention
        ret_cfg = 1;
        op_write(0, 8'h02); op_write(0, 8'h03); op_write(0, 8'h03);
        op_sleep("R4 retention deep");
        op_wake("R9 norm_wdt ignored in retention", 5'b0, 1'b1);
        op_wake("R7 retention exit all events", 5'b11111, 1'b0);
        read_chk("R5 R7 status", 1);
        read_chk("R8 keep bit kept", 0);
        // R4 keep set in the arming write itself does not count
        op_write(0, 8'h00); op_write(0, 8'h03); op_write(0, 8'h03);
        op_sleep("R4 keep too late");
        op_wake("R6 exit", 5'b10000, 1'b0);
        // R4 ret_cfg low forces plain
        ret_cfg = 0;
        op_write(0, 8'h02); op_write(0, 8'h03); op_write(0, 8'h03);
        op_sleep("R4 ret_cfg low");
        op_wake("R6 exit", 5'b11000, 1'b0);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (m_state != 0) begin
                logic [4:0] ev;
                ev = ($urandom_range(0, 2) == 0) ? 5'b0 : 5'($urandom);
                op_wake("R5 R6 R7 R9 random wake", ev, 1'($urandom));
                read_chk("R5 random status", 1);
            end else if (r < 45) begin
                op_write(0, {6'b0, 2'($urandom)});
            end else if (r < 55) begin
                op_write(3'($urandom_range(1, 7)), 8'($urandom) & 8'h7F);
            end else if (r < 65) begin
                op_step();
            end else if (r < 70) begin
                ret_cfg = 1'($urandom);
            end else begin
                op_sleep("R2 R3 R4 R10 random sleep");
            end
            if (it % 50 == 0)
                for (int a = 0; a < 6; a++) if (m_state == 0) read_chk("R8 random read", a);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule